// File: doc/BRIEF.md
# SPI Register-Access Command Decoder

This block is the serial front end of a small CAN controller's register file. An external host drives a mode-0 SPI link (clock idles low, data sampled on the rising edge, changed on the falling edge). Each transfer is framed by an active-low chip select. The first byte of a frame is an instruction. Address, mask and data bytes follow it as the instruction needs. SCLK, chip select and MOSI are brought into the system clock domain through two-flop synchronisers, and all register updates happen on the system clock.

The block owns a 128-byte register array and shows the whole of it to the surrounding controller logic on a flat output bus. The host can do the following:
- read and write registers with address auto-increment;
- change chosen bits of one register through a mask;
- load a transmit buffer without sending an address;
- read a receive buffer without sending an address, which also releases that buffer's receive flag when the frame ends;
- raise a transmit-request pulse for chosen buffers;
- return every register to its reset value.

Top module: `canreg_spi_front`

## Requirements
- R1: Instruction 0x02 followed by an address byte writes each later data byte to consecutive addresses. The address is 7 bits wide and wraps from 0x7F to 0x00.
- R2: Instruction 0x03 followed by an address byte returns register contents MSB first, from the third byte of the frame onward, at consecutive addresses. MISO is 0 during the instruction and address bytes.
- R3: Instruction 0x05 followed by address, mask and data bytes replaces only the masked bits of that register: new = (old & ~mask) | (data & mask).
- R4: Instruction 0x40 + 2·n (n = 0, 1, 2) writes the following bytes starting at address 0x31 + 16·n, with auto-increment. Instruction 0x46 is treated as unknown.
- R5: Instruction 0x90 (buffer 0) or 0x94 (buffer 1) returns data from the second byte onward, starting at address 0x61 + 16·n. When chip select rises, bit n of the interrupt-flag register at address 0x2C is cleared.
- R6: Instruction 0x80 | m (m in 0..7) produces, at the end of the instruction byte, a one-cycle pulse on rts_o[i] for each bit i set in m. With m = 0 there is no pulse.
- R7: After power-on reset, and after instruction 0xC0 (which also gives one srst_o pulse), every register is 0x00 except:
  - the status register at 0x0E, which reads 0x80 (its top three bits are the mode field, showing configuration mode);
  - the control register at 0x0F, which reads 0x87, so that control & 0x17 = 0x07.
- R8: Raising chip select in the middle of a byte discards that byte and ends the command. No register changes because of it.
- R9: An unknown instruction changes no register, and MISO stays 0 for the whole frame.
- R10: A byte whose eighth rising SCLK edge comes in the same synchronised cycle as the rise of chip select is still completed. The register write, or the receive-flag release, takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| regs_o | output | 8·2^ADDR_W | Register array, byte a at bits [8a+7:8a] |
| rts_o | output | N_TX | Per-buffer transmit-request pulse |
| srst_o | output | 1 | One-cycle pulse on soft-reset instruction |

## Verification
The final data bit of a frame and the rise of chip select can reach the decoder in the same system cycle. When they do, the byte completion and the frame abort compete. The bench provokes this by raising chip select at the same instant as the last SCLK rising edge, for both a register write and a fast receive-buffer read. It then judges the outcome on the register bus: the written byte must be present, and the receive flag must be cleared. Randomised write, bit-modify and read frames against a bench-side register model cover the ordinary paths around these corner cases.

// File: rtl/canreg_pkg.sv
package canreg_pkg;

   localparam int BYTE_W    = 8;
   localparam int STAT_ADDR = 14;
   localparam int CTRL_ADDR = 15;
   localparam int FLAG_ADDR = 44;
   localparam int TXB_BASE  = 48;
   localparam int RXB_BASE  = 96;
   localparam int BLK_SZ    = 16;
   localparam int ID_HI_OFS = 1;

   localparam logic [7:0] OP_WRITE  = 8'h02;
   localparam logic [7:0] OP_READ   = 8'h03;
   localparam logic [7:0] OP_BITMOD = 8'h05;
   localparam logic [7:0] OP_RESET  = 8'hC0;
   localparam logic [7:0] STAT_DEF  = 8'h80;
   localparam logic [7:0] CTRL_DEF  = 8'h87;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_MASK,
      ST_MODDATA,
      ST_WDATA,
      ST_RDATA,
      ST_DRAIN
   } dec_state_t;

   function automatic logic [7:0] reg_default(input int a);
      if (a == STAT_ADDR) return STAT_DEF;
      if (a == CTRL_ADDR) return CTRL_DEF;
      return 8'h00;
   endfunction

endpackage

// File: rtl/canreg_sync.sv
module canreg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("canreg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/canreg_byte_shift.sv
module canreg_byte_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         act_i,
   input  logic         sclk_rise_i,
   input  logic         sclk_fall_i,
   input  logic         mosi_i,
   input  logic         load_i,
   input  logic [W-1:0] load_byte_i,
   output logic         byte_done_o,
   output logic [W-1:0] rx_byte_o,
   output logic         miso_o
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   if (W < 2) begin : g_bad_w
      $error("canreg_byte_shift: W must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  rx_q;
   logic [W-1:0]  tx_q;

   assign byte_done_o = act_i && sclk_rise_i && (cnt_q == LAST);
   assign rx_byte_o   = {rx_q[W-2:0], mosi_i};
   assign miso_o      = tx_q[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rx_q  <= '0;
         tx_q  <= '0;
      end else if (!act_i) begin
         cnt_q <= '0;
         rx_q  <= '0;
         tx_q  <= '0;
      end else begin
         if (sclk_rise_i) begin
            rx_q  <= {rx_q[W-2:0], mosi_i};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end else if (sclk_fall_i && cnt_q != '0) begin
            tx_q <= {tx_q[W-2:0], 1'b0};
         end
         if (load_i) tx_q <= load_byte_i;
      end
   end

   // R8: leaving the frame drops any partial byte and silences MISO
   p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !act_i |=> (cnt_q == '0 && miso_o == 1'b0));
endmodule

// File: rtl/canreg_cmd_dec.sv
module canreg_cmd_dec
   import canreg_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int N_TX   = 3,
   parameter int N_RX   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_i,
   input  logic              end_i,
   input  logic              byte_done_i,
   input  logic [7:0]        rx_byte_i,
   input  logic [7:0]        rd_data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_en_o,
   output logic [7:0]        wr_data_o,
   output logic [7:0]        wr_mask_o,
   output logic              load_o,
   output logic [7:0]        load_byte_o,
   output logic [N_TX-1:0]   rts_o,
   output logic              srst_o,
   output logic [N_RX-1:0]   rxclr_o
);
   dec_state_t        st_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [7:0]        op_q;
   logic [7:0]        mask_q;
   logic [N_RX-1:0]   rx_pend_q;
   logic              load_q;

   logic is_cmd, rts_hit, tx_hit, rx_hit;

   assign is_cmd  = byte_done_i && (st_q == ST_CMD);
   assign rts_hit = (rx_byte_i[7:3] == 5'b10000);
   assign tx_hit  = (rx_byte_i[7:3] == 5'b01000) && !rx_byte_i[0]
                    && (int'(rx_byte_i[2:1]) < N_TX);
   assign rx_hit  = (rx_byte_i[7:3] == 5'b10010) && (rx_byte_i[1:0] == 2'b00)
                    && (int'(rx_byte_i[2]) < N_RX);

   for (genvar i = 0; i < N_TX; i++) begin : g_rts
      assign rts_o[i] = is_cmd && rts_hit && rx_byte_i[i];
   end

   assign srst_o      = is_cmd && (rx_byte_i == OP_RESET);
   assign wr_en_o     = byte_done_i && (st_q == ST_WDATA || st_q == ST_MODDATA);
   assign wr_mask_o   = (st_q == ST_MODDATA) ? mask_q : 8'hFF;
   assign wr_data_o   = rx_byte_i;
   assign addr_o      = ptr_q;
   assign load_o      = load_q;
   assign load_byte_o = (st_q == ST_RDATA) ? rd_data_i : 8'h00;
   assign rxclr_o     = end_i ? rx_pend_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_CMD;
         ptr_q     <= '0;
         op_q      <= '0;
         mask_q    <= '0;
         rx_pend_q <= '0;
         load_q    <= 1'b0;
      end else if (!act_i) begin
         st_q      <= ST_CMD;
         rx_pend_q <= '0;
         load_q    <= 1'b0;
      end else begin
         load_q <= byte_done_i;
         if (byte_done_i) begin
            unique case (st_q)
               ST_CMD: begin
                  op_q <= rx_byte_i;
                  if (rx_byte_i == OP_WRITE || rx_byte_i == OP_READ ||
                      rx_byte_i == OP_BITMOD) begin
                     st_q <= ST_ADDR;
                  end else if (tx_hit) begin
                     ptr_q <= ADDR_W'(TXB_BASE + BLK_SZ * int'(rx_byte_i[2:1]) + ID_HI_OFS);
                     st_q  <= ST_WDATA;
                  end else if (rx_hit) begin
                     ptr_q <= ADDR_W'(RXB_BASE + BLK_SZ * int'(rx_byte_i[2]) + ID_HI_OFS);
                     st_q  <= ST_RDATA;
                     for (int i = 0; i < N_RX; i++)
                        if (i == int'(rx_byte_i[2])) rx_pend_q[i] <= 1'b1;
                  end else begin
                     st_q <= ST_DRAIN;
                  end
               end
               ST_ADDR: begin
                  ptr_q <= rx_byte_i[ADDR_W-1:0];
                  if (op_q == OP_READ)        st_q <= ST_RDATA;
                  else if (op_q == OP_BITMOD) st_q <= ST_MASK;
                  else                        st_q <= ST_WDATA;
               end
               ST_MASK: begin
                  mask_q <= rx_byte_i;
                  st_q   <= ST_MODDATA;
               end
               ST_MODDATA: st_q  <= ST_DRAIN;
               ST_WDATA:   ptr_q <= ptr_q + 1'b1;
               ST_RDATA:   ptr_q <= ptr_q + 1'b1;
               default:    st_q  <= ST_DRAIN;
            endcase
         end
      end
   end

   // R6: request strobes are single-cycle pulses
   p_rts_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|rts_o) |=> (rts_o == '0));
   // R5: flag release only coincides with the end of a frame
   p_rxclr_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|rxclr_o) |=> !act_i);
   // R7: soft reset request is a single pulse
   p_srst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      srst_o |=> !srst_o);
   // R1: each committed data byte advances the address by one
   p_wptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && st_q == ST_WDATA) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));
endmodule

// File: rtl/canreg_store.sv
module canreg_store
   import canreg_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int N_RX   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [ADDR_W-1:0]             waddr_i,
   input  logic [7:0]                    wdata_i,
   input  logic [7:0]                    wmask_i,
   input  logic                          srst_i,
   input  logic [N_RX-1:0]               rxclr_i,
   input  logic [ADDR_W-1:0]             raddr_i,
   output logic [7:0]                    rdata_o,
   output logic [BYTE_W*(1<<ADDR_W)-1:0] regs_o
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < DEPTH; g++) begin : g_byte
      localparam logic [7:0] DEF = reg_default(g);
      logic [7:0] q, d;

      always_comb begin
         d = q;
         if (we_i && waddr_i == ADDR_W'(g))
            d = (q & ~wmask_i) | (wdata_i & wmask_i);
         if (g == FLAG_ADDR)
            d[N_RX-1:0] = d[N_RX-1:0] & ~rxclr_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= DEF;
         else if (srst_i) q <= DEF;
         else             q <= d;
      end

      assign regs_o[BYTE_W*g +: BYTE_W] = q;
   end

   assign rdata_o = regs_o[{raddr_i, 3'b000} +: BYTE_W];

   // R7: status mode field shows configuration after a soft reset
   p_stat_def_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(srst_i) |-> (regs_o[BYTE_W*STAT_ADDR +: 3'd3] == 3'b000 &&
                         regs_o[BYTE_W*STAT_ADDR + 5 +: 3] == 3'b100));
   // R7: control register check pattern after a soft reset
   p_ctrl_def_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(srst_i) |-> ((regs_o[BYTE_W*CTRL_ADDR +: BYTE_W] & 8'h17) == 8'h07));
   // R5: a released receive flag reads zero on the next cycle
   p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rxclr_i[0]) && !$past(srst_i)) |-> !regs_o[BYTE_W*FLAG_ADDR]);
endmodule

// File: rtl/canreg_spi_front.sv
module canreg_spi_front
   import canreg_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int N_TX        = 3,
   parameter int N_RX        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          spi_sclk_i,
   input  logic                          spi_cs_n_i,
   input  logic                          spi_mosi_i,
   output logic                          spi_miso_o,
   output logic [BYTE_W*(1<<ADDR_W)-1:0] regs_o,
   output logic [N_TX-1:0]               rts_o,
   output logic                          srst_o
);
   if (ADDR_W < 7 || ADDR_W > 8) begin : g_bad_addr
      $error("canreg_spi_front: ADDR_W must be 7 or 8");
   end
   if (N_TX < 1 || N_TX > 3) begin : g_bad_tx
      $error("canreg_spi_front: N_TX must be 1..3");
   end
   if (N_RX < 1 || N_RX > 2) begin : g_bad_rx
      $error("canreg_spi_front: N_RX must be 1..2");
   end

   logic sclk_s, cs_n_s, mosi_s;
   logic sclk_d, cs_n_d;
   logic sclk_rise, sclk_fall, cs_rise, frame_act;

   canreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d_i(spi_sclk_i), .q_o(sclk_s));
   canreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
      .clk(clk), .rst_n(rst_n), .d_i(spi_cs_n_i), .q_o(cs_n_s));
   canreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d_i(spi_mosi_i), .q_o(mosi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_n_d <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_n_d <= cs_n_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;
   assign cs_rise   = cs_n_s & ~cs_n_d;
   assign frame_act = ~cs_n_s | cs_rise;

   logic              byte_done, load;
   logic [7:0]        rx_byte, load_byte, rd_data, wr_data, wr_mask;
   logic [ADDR_W-1:0] addr;
   logic              wr_en;
   logic [N_RX-1:0]   rxclr;

   canreg_byte_shift #(.W(BYTE_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .act_i(frame_act),
      .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .mosi_i(mosi_s),
      .load_i(load), .load_byte_i(load_byte),
      .byte_done_o(byte_done), .rx_byte_o(rx_byte), .miso_o(spi_miso_o));

   canreg_cmd_dec #(.ADDR_W(ADDR_W), .N_TX(N_TX), .N_RX(N_RX)) i_dec (
      .clk(clk), .rst_n(rst_n), .act_i(frame_act), .end_i(cs_rise),
      .byte_done_i(byte_done), .rx_byte_i(rx_byte), .rd_data_i(rd_data),
      .addr_o(addr), .wr_en_o(wr_en), .wr_data_o(wr_data), .wr_mask_o(wr_mask),
      .load_o(load), .load_byte_o(load_byte), .rts_o(rts_o), .srst_o(srst_o),
      .rxclr_o(rxclr));

   canreg_store #(.ADDR_W(ADDR_W), .N_RX(N_RX)) i_store (
      .clk(clk), .rst_n(rst_n), .we_i(wr_en), .waddr_i(addr),
      .wdata_i(wr_data), .wmask_i(wr_mask), .srst_i(srst_o), .rxclr_i(rxclr),
      .raddr_i(addr), .rdata_o(rd_data), .regs_o(regs_o));
endmodule

// File: tb/test_canreg_spi_front.sv
`timescale 1ns/1ps
module test_canreg_spi_front;
   localparam int DEPTH = 128;
   localparam int HALF  = 40;

   logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   wire             miso;
   wire [1023:0]    regs;
   wire [2:0]       rts;
   wire             srst;

   canreg_spi_front i_canreg_spi_front (
      .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n),
      .spi_mosi_i(mosi), .spi_miso_o(miso), .regs_o(regs), .rts_o(rts),
      .srst_o(srst));

   always #2.5 clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   logic [7:0] m   [DEPTH];
   logic [7:0] txb [16];
   logic [7:0] rxb [16];
   int rts_cnt [3] = '{0, 0, 0};
   int srst_cnt = 0;

   always @(posedge clk) begin
      for (int i = 0; i < 3; i++) if (rts[i]) rts_cnt[i]++;
      if (srst) srst_cnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_regs(input string req);
      int bad = -1;
      for (int a = 0; a < DEPTH; a++)
         if (bad < 0 && regs[8*a +: 8] !== m[a]) bad = a;
      if (bad < 0) chk(1'b1, req, 0, 0);
      else chk(1'b0, $sformatf("%s reg 0x%0h", req, bad), int'(regs[8*bad +: 8]), int'(m[bad]));
   endtask

   function automatic void model_defaults();
      for (int a = 0; a < DEPTH; a++) m[a] = 8'h00;
      m[14] = 8'h80;
      m[15] = 8'h87;
   endfunction

   task automatic frame(input int nbits, input bit coincide);
      for (int i = 0; i < 16; i++) rxb[i] = 8'h00;
      cs_n = 1'b0;
      #(60);
      for (int k = 0; k < nbits; k++) begin
         automatic int bi = k / 8;
         automatic int bb = 7 - (k % 8);
         mosi = txb[bi][bb];
         #(HALF);
         rxb[bi][bb] = miso;
         sclk = 1'b1;
         if (coincide && k == nbits - 1) cs_n = 1'b1;
         #(HALF);
         sclk = 1'b0;
      end
      #(HALF);
      cs_n = 1'b1;
      mosi = 1'b0;
      #(200);
   endtask

   task automatic do_write(input int a, input int n, input bit coinc);
      txb[0] = 8'h02;
      txb[1] = 8'(a);
      frame((n + 2) * 8, coinc);
      for (int i = 0; i < n; i++) m[(a + i) % DEPTH] = txb[2 + i];
   endtask

   task automatic do_read(input int a, input int n, input string req);
      txb[0] = 8'h03;
      txb[1] = 8'(a);
      for (int i = 0; i < n; i++) txb[2 + i] = 8'h00;
      frame((n + 2) * 8, 1'b0);
      chk(rxb[0] == 8'h00 && rxb[1] == 8'h00, {req, " MISO idle in header"},
          int'({rxb[0], rxb[1]}), 0);
      for (int i = 0; i < n; i++)
         chk(rxb[2 + i] === m[(a + i) % DEPTH], $sformatf("%s read @0x%0h", req, (a + i) % DEPTH),
             int'(rxb[2 + i]), int'(m[(a + i) % DEPTH]));
   endtask

   task automatic do_bitmod(input int a, input logic [7:0] mk, input logic [7:0] dt);
      txb[0] = 8'h05; txb[1] = 8'(a); txb[2] = mk; txb[3] = dt;
      frame(32, 1'b0);
      m[a] = (m[a] & ~mk) | (dt & mk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=0x0 expected=0x1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int r0, r1, r2;
      void'($urandom(32'd7301));
      model_defaults();
      #(23);
      rst_n = 1'b1;
      #(100);

      // R7: power-on defaults
      chk_regs("R7 power-on defaults");
      chk(miso == 1'b0, "R7 MISO idle", int'(miso), 0);

      // R2: read status and control through SPI
      do_read(14, 2, "R2");

      // R1: write with auto-increment, then wrap 0x7F -> 0x00
      txb[2] = 8'hA1; txb[3] = 8'hB2; txb[4] = 8'hC3;
      do_write(16, 3, 1'b0);
      chk_regs("R1 burst write");
      txb[2] = 8'h11; txb[3] = 8'h22;
      do_write(127, 2, 1'b0);
      chk_regs("R1 address wrap");
      do_read(127, 2, "R2 wrap");

      // R3: masked bit modify
      do_bitmod(16, 8'hF0, 8'h5A);
      chk(regs[8*16 +: 8] == 8'h51, "R3 bit modify", int'(regs[8*16 +: 8]), 8'h51);
      chk_regs("R3 others untouched");

      // R4: direct transmit buffer loads
      for (int n = 0; n < 3; n++) begin
         txb[0] = 8'(8'h40 + 2 * n);
         for (int i = 0; i < 3; i++) txb[1 + i] = 8'(8'h10 * (n + 1) + i);
         frame(32, 1'b0);
         for (int i = 0; i < 3; i++) m[49 + 16 * n + i] = txb[1 + i];
         chk_regs($sformatf("R4 load tx%0d", n));
      end
      txb[0] = 8'h46; txb[1] = 8'hEE; txb[2] = 8'hEE;
      frame(24, 1'b0);
      chk_regs("R4 opcode 0x46 ignored");

      // R5: fast receive reads and flag release
      txb[2] = 8'h03;
      do_write(44, 1, 1'b0);
      txb[2] = 8'h9A; txb[3] = 8'h9B; txb[4] = 8'h9C;
      do_write(97, 3, 1'b0);
      txb[2] = 8'h5D; txb[3] = 8'h5E;
      do_write(113, 2, 1'b0);
      txb[0] = 8'h90; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
      frame(32, 1'b0);
      chk(rxb[0] == 8'h00, "R5 MISO idle during opcode", int'(rxb[0]), 0);
      for (int i = 0; i < 3; i++)
         chk(rxb[1 + i] === m[97 + i], "R5 rx0 data", int'(rxb[1 + i]), int'(m[97 + i]));
      m[44] = m[44] & 8'hFE;
      chk_regs("R5 rx0 flag cleared");
      txb[0] = 8'h94; txb[1] = 8'h00; txb[2] = 8'h00;
      frame(24, 1'b0);
      chk(rxb[1] === m[113] && rxb[2] === m[114], "R5 rx1 data",
          int'({rxb[1], rxb[2]}), int'({m[113], m[114]}));
      m[44] = m[44] & 8'hFD;
      chk_regs("R5 rx1 flag cleared");

      // R6: transmit request strobes
      r0 = rts_cnt[0]; r1 = rts_cnt[1]; r2 = rts_cnt[2];
      txb[0] = 8'h85;
      frame(8, 1'b0);
      chk(rts_cnt[0] == r0 + 1 && rts_cnt[1] == r1 && rts_cnt[2] == r2 + 1,
          "R6 rts mask 101", (rts_cnt[2]-r2)*4 + (rts_cnt[1]-r1)*2 + (rts_cnt[0]-r0), 5);
      r0 = rts_cnt[0]; r1 = rts_cnt[1]; r2 = rts_cnt[2];
      txb[0] = 8'h80;
      frame(8, 1'b0);
      chk(rts_cnt[0] == r0 && rts_cnt[1] == r1 && rts_cnt[2] == r2,
          "R6 rts mask 000", (rts_cnt[2]-r2)*4 + (rts_cnt[1]-r1)*2 + (rts_cnt[0]-r0), 0);
      chk_regs("R6 registers untouched");

      // R8: partial byte abort
      txb[0] = 8'h02; txb[1] = 8'h20; txb[2] = 8'hFF;
      frame(21, 1'b0);
      chk_regs("R8 partial byte discarded");
      txb[2] = 8'h3C;
      do_write(32, 1, 1'b0);
      chk_regs("R8 next frame clean");

      // R9: unknown opcode
      txb[0] = 8'hA5; txb[1] = 8'hFF; txb[2] = 8'hFF;
      frame(24, 1'b0);
      chk(rxb[0] == 0 && rxb[1] == 0 && rxb[2] == 0, "R9 MISO zero",
          int'({rxb[0], rxb[1], rxb[2]}), 0);
      chk_regs("R9 no change");

      // R10: last bit and chip-select rise in the same cycle
      txb[2] = 8'h77;
      do_write(48, 1, 1'b1);
      chk_regs("R10 coincident write committed");
      txb[2] = 8'h01;
      do_write(44, 1, 1'b0);
      txb[0] = 8'h90; txb[1] = 8'h00;
      frame(16, 1'b1);
      chk(rxb[1] === m[97], "R10 coincident rx data", int'(rxb[1]), int'(m[97]));
      m[44] = m[44] & 8'hFE;
      chk_regs("R10 coincident flag release");

      // R1 R2 R3: random mix against the model
      for (int it = 0; it < 30; it++) begin
         automatic int kind = int'($urandom % 3);
         automatic int a    = int'($urandom % DEPTH);
         automatic int n    = 1 + int'($urandom % 4);
         if (kind == 0) begin
            for (int i = 0; i < n; i++) txb[2 + i] = 8'($urandom);
            do_write(a, n, 1'b0);
            chk_regs("R1 random write");
         end else if (kind == 1) begin
            do_bitmod(a, 8'($urandom), 8'($urandom));
            chk_regs("R3 random bit modify");
         end else begin
            do_read(a, n, "R2 random");
         end
      end

      // R7: soft reset instruction
      r0 = srst_cnt;
      txb[0] = 8'hC0; txb[1] = 8'hFF;
      frame(16, 1'b0);
      chk(srst_cnt == r0 + 1, "R7 reset pulse count", srst_cnt - r0, 1);
      model_defaults();
      chk_regs("R7 soft reset defaults");
      chk((regs[8*15 +: 8] & 8'h17) == 8'h07, "R7 control check pattern",
          int'(regs[8*15 +: 8] & 8'h17), 7);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule